// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block decides, when the processor core asks to quiesce, how much of the chip goes to sleep with it. A single configuration word holds two enables: one for the whole system and one for the external DDR memory. If the system enable is clear, only the core sleeps and a core-sleep output is raised. If it is set, the system enters its low-power state. When the memory enable is also set, the DDR clocks are stopped and, if the memory controller permits it, self-refresh is requested.

Leaving the low-power state follows a fixed order. A wake event first restarts the memory clocks. One cycle later self-refresh is released. One cycle after that the low-power output drops and both enables clear themselves, so software has to arm them again before the next quiesce. The enables are sampled in the cycle the quiesce request is seen. From that point until the sequence returns to its running state, register writes are discarded.

Top module: `lp_seq_ctrl`

## Requirements
- R1: After reset the configuration word reads zero and core_sleep, sys_lowpower, mem_self_refresh and mem_clk_stop are all low.
- R2: A write at the configuration offset (default 0xB00) stores wdata bit 0 as the system enable and bit 1 as the memory enable. Bits 31:2 always read zero. A write at any other address changes nothing, and a read at any other address returns zero.
- R3: A quiesce request seen in the running state with the system enable set raises sys_lowpower in the next cycle. It stays high until a wake event starts the exit.
- R4: A quiesce request seen in the running state with the system enable clear raises only core_sleep in the next cycle. A wake event drops core_sleep in the following cycle and leaves the configuration word unchanged.
- R5: With the system enable clear, the memory enable has no effect: mem_self_refresh and mem_clk_stop stay low.
- R6: With both enables set, mem_clk_stop rises two cycles after the quiesce cycle, whatever the self-refresh-allowed input is.
- R7: mem_self_refresh rises one cycle after the quiesce cycle only when both enables are set and sr_allowed was high in the quiesce cycle. Its later value does not matter.
- R8: A wake event in the low-power state clears mem_clk_stop in the next cycle and mem_self_refresh one cycle after that. In the third cycle sys_lowpower is low and the configuration word reads zero.
- R9: Register writes are discarded from the entry cycle until the system is running again. In the running and core-sleep states they take effect.
- R10: A write in the same cycle as the quiesce request updates the register, but the sleep path follows the enables held before that write.
- R11: A wake event while running or during the entry cycle is ignored. A quiesce request while the core sleeps is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| quiesce_req | input | 1 | Sleep request from the core |
| wake_evt | input | 1 | Wake event |
| sr_allowed | input | 1 | Memory controller permits self-refresh |
| core_sleep | output | 1 | Only the core is asleep |
| sys_lowpower | output | 1 | System is in low-power state |
| mem_self_refresh | output | 1 | Request DDR self-refresh |
| mem_clk_stop | output | 1 | DDR clocks stopped |

## Verification
Two things can land on the same clock edge: a register write and the quiesce request that samples that same register. The bench drives both together, in one direction from a cleared word to a set one and in the other from set to cleared. It then judges the sleep path taken by the pre-write enables and the readback by the post-write value. Around this, all eight combinations of the two enables and sr_allowed are swept through a full entry and exit, with every output checked in every cycle.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    localparam int SYS_BIT = 0;
    localparam int MEM_BIT = 1;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_CSLEEP = 3'd1,
        ST_ENTER  = 3'd2,
        ST_LOWPWR = 3'd3,
        ST_WAKE   = 3'd4,
        ST_EXIT   = 3'd5
    } lp_state_e;

    typedef struct packed {
        lp_state_e state;
        logic      mem_act;
        logic      lowpower;
        logic      self_ref;
        logic      clk_stop;
        logic      core_sleep;
    } seq_t;

endpackage

// File: rtl/lp_cfg_reg.sv
module lp_cfg_reg
    import lp_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CFG_OFFSET = 'hB00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wr_allow,
    input  logic              clr,
    output logic              sys_en,
    output logic              mem_en,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] OFFS    = ADDR_W'(CFG_OFFSET);
    localparam logic [DATA_W-1:0] WR_MASK = (DATA_W'(1) << SYS_BIT) | (DATA_W'(1) << MEM_BIT);

    logic [DATA_W-1:0] cfg_d, cfg_q;
    logic              hit;

    assign hit = (bus_addr == OFFS);

    always_comb begin
        cfg_d = cfg_q;
        if (clr)
            cfg_d = '0;
        else if (bus_wr && hit && wr_allow)
            cfg_d = bus_wdata & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_rd
            if (WR_MASK[i]) begin : g_live
                assign bus_rdata[i] = hit & cfg_q[i];
            end else begin : g_rsvd
                assign bus_rdata[i] = 1'b0;
            end
        end
    endgenerate

    assign sys_en = cfg_q[SYS_BIT];
    assign mem_en = cfg_q[MEM_BIT];

endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
    import lp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic quiesce_req,
    input  logic wake_evt,
    input  logic sr_allowed,
    input  logic sys_en,
    input  logic mem_en,
    output logic wr_allow,
    output logic clr,
    output logic core_sleep,
    output logic sys_lowpower,
    output logic mem_self_refresh,
    output logic mem_clk_stop
);

    localparam seq_t SEQ_RST = '{state: ST_RUN, default: 1'b0};

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        clr      = 1'b0;
        wr_allow = (seq_q.state == ST_RUN) || (seq_q.state == ST_CSLEEP);
        case (seq_q.state)
            ST_RUN: begin
                if (quiesce_req) begin
                    if (sys_en) begin
                        seq_d.state    = ST_ENTER;
                        seq_d.lowpower = 1'b1;
                        seq_d.mem_act  = mem_en;
                        seq_d.self_ref = mem_en & sr_allowed;
                    end else begin
                        seq_d.state      = ST_CSLEEP;
                        seq_d.core_sleep = 1'b1;
                    end
                end
            end
            ST_CSLEEP: begin
                if (wake_evt) begin
                    seq_d.state      = ST_RUN;
                    seq_d.core_sleep = 1'b0;
                end
            end
            ST_ENTER: begin
                seq_d.state    = ST_LOWPWR;
                seq_d.clk_stop = seq_q.mem_act;
            end
            ST_LOWPWR: begin
                if (wake_evt) begin
                    seq_d.state    = ST_WAKE;
                    seq_d.clk_stop = 1'b0;
                end
            end
            ST_WAKE: begin
                seq_d.state    = ST_EXIT;
                seq_d.self_ref = 1'b0;
            end
            ST_EXIT: begin
                seq_d.state    = ST_RUN;
                seq_d.lowpower = 1'b0;
                seq_d.mem_act  = 1'b0;
                clr            = 1'b1;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign core_sleep       = seq_q.core_sleep;
    assign sys_lowpower     = seq_q.lowpower;
    assign mem_self_refresh = seq_q.self_ref;
    assign mem_clk_stop     = seq_q.clk_stop;

endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int CFG_OFFSET = 'hB00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              quiesce_req,
    input  logic              wake_evt,
    input  logic              sr_allowed,
    output logic              core_sleep,
    output logic              sys_lowpower,
    output logic              mem_self_refresh,
    output logic              mem_clk_stop
);

    logic sys_en, mem_en, wr_allow, clr;

    lp_cfg_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CFG_OFFSET(CFG_OFFSET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .wr_allow (wr_allow),
        .clr      (clr),
        .sys_en   (sys_en),
        .mem_en   (mem_en),
        .bus_rdata(bus_rdata)
    );

    lp_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .quiesce_req     (quiesce_req),
        .wake_evt        (wake_evt),
        .sr_allowed      (sr_allowed),
        .sys_en          (sys_en),
        .mem_en          (mem_en),
        .wr_allow        (wr_allow),
        .clr             (clr),
        .core_sleep      (core_sleep),
        .sys_lowpower    (sys_lowpower),
        .mem_self_refresh(mem_self_refresh),
        .mem_clk_stop    (mem_clk_stop)
    );

endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              quiesce_req,
    input logic              core_sleep,
    input logic              sys_lowpower,
    input logic              mem_self_refresh,
    input logic              mem_clk_stop
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:2] == '0);

    a_r4_sleep_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_sleep && sys_lowpower));

    a_r5_clk_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_clk_stop |-> sys_lowpower);

    a_r5_sr_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_self_refresh |-> sys_lowpower);

    a_r3_lp_from_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_lowpower) |-> $past(quiesce_req));

    a_r4_cs_from_quiesce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_sleep) |-> $past(quiesce_req));

    a_r6_clk_after_lp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_clk_stop) |-> $past(sys_lowpower));

    a_r8_clk_before_sr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_self_refresh) |-> !mem_clk_stop);

    a_r8_sr_before_lp: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_lowpower) |-> !$past(mem_self_refresh));

endmodule

bind lp_seq_ctrl lp_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_rdata       (bus_rdata),
    .quiesce_req     (quiesce_req),
    .core_sleep      (core_sleep),
    .sys_lowpower    (sys_lowpower),
    .mem_self_refresh(mem_self_refresh),
    .mem_clk_stop    (mem_clk_stop)
);

// File: tb/tb_lp_seq_ctrl.sv
module tb_lp_seq_ctrl;

    localparam int OFFS = 'hB00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'(OFFS);
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        quiesce_req = 1'b0;
    logic        wake_evt = 1'b0;
    logic        sr_allowed = 1'b0;
    logic        core_sleep, sys_lowpower, mem_self_refresh, mem_clk_stop;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lp_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .quiesce_req(quiesce_req),
        .wake_evt(wake_evt), .sr_allowed(sr_allowed), .core_sleep(core_sleep),
        .sys_lowpower(sys_lowpower), .mem_self_refresh(mem_self_refresh),
        .mem_clk_stop(mem_clk_stop)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // expected order: {core_sleep, sys_lowpower, mem_self_refresh, mem_clk_stop}
    task automatic chk_out(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {core_sleep, sys_lowpower, mem_self_refresh, mem_clk_stop};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s outputs act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_rd(string req, logic [15:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s rdata@%h act=%h exp=%h", req, a, bus_rdata, exp);
        end
        bus_addr = 16'(OFFS);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = 16'(OFFS);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=expired exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_out("R1", 4'b0000);
        chk_rd("R1", 16'(OFFS), 32'h0);

        // R2 field placement, reserved bits, other addresses
        wr(16'(OFFS), 32'hFFFF_FFFF);
        chk_rd("R2", 16'(OFFS), 32'h3);
        wr(16'(OFFS), 32'hFFFF_FFFE);
        chk_rd("R2", 16'(OFFS), 32'h2);
        wr(16'(OFFS + 4), 32'h1);
        chk_rd("R2", 16'(OFFS), 32'h2);
        chk_rd("R2", 16'(OFFS + 4), 32'h0);
        wr(16'(OFFS), 32'h0);
        chk_rd("R2", 16'(OFFS), 32'h0);

        // sweep over system enable, memory enable, self-refresh allowed
        for (int c = 0; c < 8; c++) begin
            logic s, m, a, ma, sr;
            s = c[0]; m = c[1]; a = c[2];
            ma = s & m;
            sr = ma & a;
            wr(16'(OFFS), {30'b0, m, s});
            sr_allowed = a;
            quiesce_req = 1'b1;
            tick();
            quiesce_req = 1'b0;
            sr_allowed = ~a;   // R7: only the quiesce-cycle value counts
            if (s) begin
                chk_out("R3 R7 entry", {1'b0, 1'b1, sr, 1'b0});
                wr(16'(OFFS), 32'h0);                 // R9 write during entry
                chk_out("R6 clock stop", {1'b0, 1'b1, sr, ma});
                chk_rd("R9 entry write ignored", 16'(OFFS), {30'b0, m, s});
                wr(16'(OFFS), 32'h0);                 // R9 write in low power
                chk_out("R3 hold", {1'b0, 1'b1, sr, ma});
                chk_rd("R9 lowpower write ignored", 16'(OFFS), {30'b0, m, s});
                wake_evt = 1'b1;
                tick();
                wake_evt = 1'b0;
                chk_out("R8 clock release", {1'b0, 1'b1, sr, 1'b0});
                tick();
                chk_out("R8 sr release", 4'b0100);
                tick();
                chk_out("R8 lowpower drop", 4'b0000);
                chk_rd("R8 enables cleared", 16'(OFFS), 32'h0);
            end else begin
                chk_out("R4 R5 core sleep", 4'b1000);
                quiesce_req = 1'b1;                   // R11 ignored while asleep
                tick();
                quiesce_req = 1'b0;
                chk_out("R11 R5 hold", 4'b1000);
                wake_evt = 1'b1;
                tick();
                wake_evt = 1'b0;
                chk_out("R4 wake", 4'b0000);
                chk_rd("R4 register kept", 16'(OFFS), {30'b0, m, 1'b0});
            end
        end

        // R10 write and quiesce in one cycle: cleared -> set
        wr(16'(OFFS), 32'h0);
        sr_allowed = 1'b1;
        bus_wdata = 32'h3; bus_wr = 1'b1; quiesce_req = 1'b1;
        tick();
        bus_wr = 1'b0; quiesce_req = 1'b0;
        chk_out("R10 old enables used", 4'b1000);
        chk_rd("R10 write landed", 16'(OFFS), 32'h3);
        wr(16'(OFFS), 32'h0);                         // R9 writes accepted in core sleep
        chk_rd("R9 core sleep write", 16'(OFFS), 32'h0);
        wr(16'(OFFS), 32'h3);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        chk_out("R4 wake", 4'b0000);

        // R10 write and quiesce in one cycle: set -> cleared
        bus_wdata = 32'h0; bus_wr = 1'b1; quiesce_req = 1'b1;
        tick();
        bus_wr = 1'b0; quiesce_req = 1'b0;
        chk_out("R10 old enables used", 4'b0110);
        chk_rd("R10 write landed", 16'(OFFS), 32'h0);
        tick();
        chk_out("R10 clock stop", 4'b0111);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        repeat (2) tick();
        chk_out("R8 exit", 4'b0000);

        // R11 wake while running, wake during entry
        wr(16'(OFFS), 32'h1);
        wake_evt = 1'b1;
        tick();
        chk_out("R11 wake in run", 4'b0000);
        wake_evt = 1'b0;
        quiesce_req = 1'b1;
        tick();
        quiesce_req = 1'b0;
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        tick();
        chk_out("R11 wake in entry ignored", 4'b0100);
        wake_evt = 1'b1;
        tick();
        wake_evt = 1'b0;
        repeat (2) tick();
        chk_out("R8 exit", 4'b0000);
        chk_rd("R8 cleared", 16'(OFFS), 32'h0);

        finish_run();
    end

endmodule